// File: doc/BRIEF.md
# Linear Sensor Drive Clock Sequencer

This block turns a fast master clock into the digital drive pattern for a three-colour linear image sensor with two output taps per colour. It produces a complementary pair of shift clocks, a copy of the first phase for the final register stage, a reset-gate pulse, a clamp pulse and a single transfer-gate pulse that all three colours share. Every timing value is a register input counted in master-clock ticks. A value of zero means "use the typical value" that is fixed by a parameter.

Each line begins with a one-cycle start strobe. The sequencer stops shifting and waits a setup gap, then raises the transfer gate. It waits a hold gap after the gate falls, then runs a fixed number of shift cycles to read the line out. Two clamp schemes are supported. In per-pixel clamping, the reset pulse and the clamp pulse fire in every pixel cycle, and they keep firing while the transfer gate is high. In per-line clamping, the reset gate stays high around the transfer event and the clamp pulse fires only inside the transfer-gate pulse. A strobe that arrives while a line is in progress is kept and starts the next line as soon as the current one ends.

Top module: `ccd_clk_seq`

## Requirements
- R1: During and after reset, phi1 and phi1_last are high, phi2 is low, and tg, clb and line_active are low.
- R2: phi2 is always the inverse of phi1, and phi1_last always equals phi1.
- R3: When start_line is sampled while idle, tg goes high at the clock edge that comes setup-ticks edges after the sampling edge. phi1 is held high during the setup gap.
- R4: tg stays high for exactly tg-ticks cycles, and phi1 is held high for the whole time.
- R5: After tg falls, the first fall of phi1 comes no sooner than hold-ticks + HALF_TICKS cycles and no later than hold-ticks + 3*HALF_TICKS - 1 cycles. Readout starts only on a pixel-cycle boundary.
- R6: Readout consists of exactly LINE_CYCLES shift cycles. In each one, phi1 is high for HALF_TICKS cycles and then low for HALF_TICKS cycles.
- R7: line_active rises in the same cycle as tg. It falls in the cycle in which phi1 returns high after the last shift cycle.
- R8: In per-pixel mode (clamp_line=0), rb is high for rb-ticks cycles starting when phi1's low half begins. clb rises in the cycle rb falls, stays high for clb-ticks cycles, is cut off at the end of the pixel cycle, and never overlaps rb. These pulses continue while tg is high.
- R9: In per-line mode (clamp_line=1), rb is high throughout tg. clb rises lead-ticks cycles after tg rises and falls lag-ticks cycles before tg falls. clb is never high while tg is low.
- R10: A start_line strobe sampled during a line does not cut that line short. The next line's setup gap starts in the cycle line_active falls, so tg rises setup-ticks cycles later.
- R11: A timing register loaded with zero acts as the typical value given by its parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_line | input | 1 | One-cycle strobe that requests a line |
| clamp_line | input | 1 | 0 = per-pixel clamp, 1 = per-line clamp |
| cfg_setup | input | TW | Gap from end of shifting to tg rising, in ticks |
| cfg_tg | input | TW | Transfer-gate pulse width, in ticks |
| cfg_hold | input | TW | Minimum gap from tg falling to shifting, in ticks |
| cfg_rb | input | TW | Reset-gate pulse width, in ticks |
| cfg_clb | input | TW | Per-pixel clamp pulse width, in ticks |
| cfg_lead | input | TW | Per-line clamp delay after tg rises, in ticks |
| cfg_lag | input | TW | Per-line clamp margin before tg falls, in ticks |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2, complement of phi1 |
| phi1_last | output | 1 | Last-stage shift clock, follows phi1 |
| rb | output | 1 | Reset-gate pulse |
| clb | output | 1 | Clamp pulse |
| tg | output | 1 | Transfer-gate pulse shared by all colours |
| line_active | output | 1 | High from tg rising to the end of readout |

## Verification
The hardest case to reach is a start strobe that lands while readout is in progress, because it must survive until the last shift cycle and then start the next line with no idle cycle. The bench waits until the current line has shown two falls of phi1, pulses the strobe, and then times the next gate rise from the fall of line_active. Readout begins on a pixel-cycle boundary, so its exact start depends on the free-running pixel phase. For that reason the bench checks the hold gap against a window one pixel cycle wide, and it sweeps several combinations of setup and gate width so that different phase offsets occur.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_TG    = 3'd2,
      ST_HOLD  = 3'd3,
      ST_READ  = 3'd4
   } seq_state_t;

   localparam int CF_SETUP = 0;
   localparam int CF_TG    = 1;
   localparam int CF_HOLD  = 2;
   localparam int CF_RB    = 3;
   localparam int CF_CLB   = 4;
   localparam int CF_LEAD  = 5;
   localparam int CF_LAG   = 6;
   localparam int CF_NUM   = 7;
endpackage

// File: rtl/ccd_reg_default.sv
module ccd_reg_default #(
   parameter int unsigned TW  = 16,
   parameter int unsigned TYP = 1
) (
   input  logic [TW-1:0] raw,
   output logic [TW-1:0] eff
);
   generate
      if (TYP == 0 || TYP >= (64'd1 << TW)) begin : g_bad_typ
         $error("typical value must be nonzero and fit in TW bits");
      end
   endgenerate

   // zero in the register selects the typical value
   assign eff = (raw == '0) ? TW'(TYP) : raw;
endmodule

// File: rtl/ccd_pixel_phase.sv
module ccd_pixel_phase #(
   parameter int unsigned HALF_TICKS = 25,
   localparam int unsigned PW = $clog2(2 * HALF_TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] pos,
   output logic          wrap
);
   localparam logic [PW-1:0] LAST = PW'(2 * HALF_TICKS - 1);

   assign wrap = (pos == LAST);

   // free-running phase so clamp pulses are never truncated at state changes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (wrap) pos <= '0;
      else           pos <= pos + 1'b1;
   end
endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
   import ccd_seq_pkg::*;
#(
   parameter int unsigned TW          = 16,
   parameter int unsigned LINE_CYCLES = 3719,
   localparam int unsigned CW = $clog2(LINE_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          pix_wrap,
   input  logic [TW-1:0] setup_t,
   input  logic [TW-1:0] tg_t,
   input  logic [TW-1:0] hold_t,
   output seq_state_t    state,
   output logic [TW-1:0] cnt,
   output logic          line_active
);
   localparam logic [CW-1:0] CYC_LAST = CW'(LINE_CYCLES - 1);

   logic [CW-1:0] cyc;
   logic          pend;
   logic          read_done;
   logic          next_line;

   assign read_done   = (state == ST_READ) && pix_wrap && (cyc == CYC_LAST);
   assign next_line   = pend || start;
   assign line_active = (state == ST_TG) || (state == ST_HOLD) || (state == ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         cyc   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_SETUP;
               cnt   <= '0;
            end
            ST_SETUP: if (cnt == setup_t - 1'b1) begin
               state <= ST_TG;
               cnt   <= '0;
            end else cnt <= cnt + 1'b1;
            ST_TG: if (cnt == tg_t - 1'b1) begin
               state <= ST_HOLD;
               cnt   <= '0;
            end else cnt <= cnt + 1'b1;
            ST_HOLD: if (cnt >= hold_t - 1'b1) begin
               if (pix_wrap) begin
                  state <= ST_READ;
                  cyc   <= '0;
               end
            end else cnt <= cnt + 1'b1;
            ST_READ: if (pix_wrap) begin
               if (cyc == CYC_LAST) begin
                  state <= next_line ? ST_SETUP : ST_IDLE;
                  cnt   <= '0;
               end else cyc <= cyc + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // a strobe seen while busy waits for the line to finish
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend <= 1'b0;
      else if (state == ST_IDLE)   pend <= 1'b0;
      else if (read_done)          pend <= 1'b0;
      else if (start)              pend <= 1'b1;
   end

   p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start && !read_done) |=> pend);
   p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (read_done && next_line) |=> (state == ST_SETUP));
   p_setup_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETUP && cnt == setup_t - 1'b1) |=> (state == ST_TG));
endmodule

// File: rtl/ccd_pulse_gen.sv
module ccd_pulse_gen
   import ccd_seq_pkg::*;
#(
   parameter int unsigned TW         = 16,
   parameter int unsigned HALF_TICKS = 25,
   localparam int unsigned PW = $clog2(2 * HALF_TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  seq_state_t    state,
   input  logic [TW-1:0] cnt,
   input  logic [PW-1:0] pos,
   input  logic          clamp_line,
   input  logic [TW-1:0] tg_t,
   input  logic [TW-1:0] rb_t,
   input  logic [TW-1:0] clb_t,
   input  logic [TW-1:0] lead_t,
   input  logic [TW-1:0] lag_t,
   output logic          phi1,
   output logic          rb,
   output logic          clb,
   output logic          tg
);
   localparam logic [TW:0] HX = (TW+1)'(HALF_TICKS);

   logic [TW:0] pos_x, rel, rb_end, clb_end;
   logic        low_half, bit_rb, bit_clb, gate_win, line_clb;

   assign pos_x    = (TW+1)'(pos);
   assign low_half = (pos_x >= HX);
   assign rel      = pos_x - HX;
   assign rb_end   = {1'b0, rb_t};
   assign clb_end  = {1'b0, rb_t} + {1'b0, clb_t};

   // per-pixel pulses sit in the low half of phi1; the pixel end clips clb
   assign bit_rb  = low_half && (rel < rb_end);
   assign bit_clb = low_half && (rel >= rb_end) && (rel < clb_end);

   assign tg       = (state == ST_TG);
   assign gate_win = (state == ST_SETUP) || (state == ST_TG) || (state == ST_HOLD);
   assign line_clb = tg && (cnt >= lead_t) &&
                     (({1'b0, cnt} + {1'b0, lag_t}) < {1'b0, tg_t});

   assign phi1 = (state != ST_READ) || (pos_x < HX);
   assign rb   = clamp_line ? (gate_win || bit_rb) : bit_rb;
   assign clb  = clamp_line ? line_clb : bit_clb;

   p_tg_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tg |-> phi1);
   p_bit_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clamp_line |-> !(rb && clb));
   p_line_rb_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_line && tg) |-> rb);
   p_line_clb_in_tg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_line && clb) |-> tg);
endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
   import ccd_seq_pkg::*;
#(
   parameter int unsigned TW          = 16,
   parameter int unsigned HALF_TICKS  = 25,
   parameter int unsigned LINE_CYCLES = 3719,
   parameter int unsigned TYP_SETUP   = 100,
   parameter int unsigned TYP_TG      = 1000,
   parameter int unsigned TYP_HOLD    = 100,
   parameter int unsigned TYP_RB      = 5,
   parameter int unsigned TYP_CLB     = 15,
   parameter int unsigned TYP_LEAD    = 100,
   parameter int unsigned TYP_LAG     = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_line,
   input  logic          clamp_line,
   input  logic [TW-1:0] cfg_setup,
   input  logic [TW-1:0] cfg_tg,
   input  logic [TW-1:0] cfg_hold,
   input  logic [TW-1:0] cfg_rb,
   input  logic [TW-1:0] cfg_clb,
   input  logic [TW-1:0] cfg_lead,
   input  logic [TW-1:0] cfg_lag,
   output logic          phi1,
   output logic          phi2,
   output logic          phi1_last,
   output logic          rb,
   output logic          clb,
   output logic          tg,
   output logic          line_active
);
   localparam int unsigned PW = $clog2(2 * HALF_TICKS);
   localparam int unsigned TYPS [CF_NUM] =
      '{TYP_SETUP, TYP_TG, TYP_HOLD, TYP_RB, TYP_CLB, TYP_LEAD, TYP_LAG};

   generate
      if (HALF_TICKS < 2)  begin : g_bad_half  $error("HALF_TICKS must be at least 2"); end
      if (LINE_CYCLES < 1) begin : g_bad_line  $error("LINE_CYCLES must be at least 1"); end
      if (PW >= TW)        begin : g_bad_width $error("TW too narrow for the pixel phase"); end
   endgenerate

   logic [TW-1:0] raw [CF_NUM];
   logic [TW-1:0] eff [CF_NUM];

   assign raw[CF_SETUP] = cfg_setup;
   assign raw[CF_TG]    = cfg_tg;
   assign raw[CF_HOLD]  = cfg_hold;
   assign raw[CF_RB]    = cfg_rb;
   assign raw[CF_CLB]   = cfg_clb;
   assign raw[CF_LEAD]  = cfg_lead;
   assign raw[CF_LAG]   = cfg_lag;

   for (genvar i = 0; i < CF_NUM; i++) begin : g_fill
      ccd_reg_default #(.TW(TW), .TYP(TYPS[i])) u_fill (
         .raw (raw[i]),
         .eff (eff[i])
      );
   end

   seq_state_t    state;
   logic [TW-1:0] cnt;
   logic [PW-1:0] pos;
   logic          pix_wrap;

   ccd_pixel_phase #(.HALF_TICKS(HALF_TICKS)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (pos),
      .wrap  (pix_wrap)
   );

   ccd_seq_ctrl #(.TW(TW), .LINE_CYCLES(LINE_CYCLES)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start_line),
      .pix_wrap    (pix_wrap),
      .setup_t     (eff[CF_SETUP]),
      .tg_t        (eff[CF_TG]),
      .hold_t      (eff[CF_HOLD]),
      .state       (state),
      .cnt         (cnt),
      .line_active (line_active)
   );

   ccd_pulse_gen #(.TW(TW), .HALF_TICKS(HALF_TICKS)) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .cnt        (cnt),
      .pos        (pos),
      .clamp_line (clamp_line),
      .tg_t       (eff[CF_TG]),
      .rb_t       (eff[CF_RB]),
      .clb_t      (eff[CF_CLB]),
      .lead_t     (eff[CF_LEAD]),
      .lag_t      (eff[CF_LAG]),
      .phi1       (phi1),
      .rb         (rb),
      .clb        (clb),
      .tg         (tg)
   );

   assign phi2      = ~phi1;
   assign phi1_last = phi1;

   p_active_with_tg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tg) |-> line_active);
endmodule

// File: tb/ccd_clk_seq_test.sv
module ccd_clk_seq_test;
   localparam int TW = 12, H = 6, L = 5;
   localparam int TYP_SETUP = 3, TYP_TG = 16, TYP_HOLD = 2, TYP_RB = 2;
   localparam int TYP_CLB = 3, TYP_LEAD = 2, TYP_LAG = 2;

   logic clk = 1'b0, rst_n = 1'b0, start_line = 1'b0, clamp_line = 1'b0;
   logic [TW-1:0] cfg_setup = '0, cfg_tg = '0, cfg_hold = '0, cfg_rb = '0;
   logic [TW-1:0] cfg_clb = '0, cfg_lead = '0, cfg_lag = '0;
   logic phi1, phi2, phi1_last, rb, clb, tg, line_active;

   ccd_clk_seq #(.TW(TW), .HALF_TICKS(H), .LINE_CYCLES(L),
      .TYP_SETUP(TYP_SETUP), .TYP_TG(TYP_TG), .TYP_HOLD(TYP_HOLD), .TYP_RB(TYP_RB),
      .TYP_CLB(TYP_CLB), .TYP_LEAD(TYP_LEAD), .TYP_LAG(TYP_LAG)) uut (
      .clk(clk), .rst_n(rst_n), .start_line(start_line), .clamp_line(clamp_line),
      .cfg_setup(cfg_setup), .cfg_tg(cfg_tg), .cfg_hold(cfg_hold), .cfg_rb(cfg_rb),
      .cfg_clb(cfg_clb), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
      .phi1(phi1), .phi2(phi2), .phi1_last(phi1_last), .rb(rb), .clb(clb),
      .tg(tg), .line_active(line_active));

   always #10 clk = ~clk;

   int errors = 0, checks = 0, cycles = 0;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++; checks++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // edge monitor, sampled at the falling clock edge
   int t = 0;
   logic p_tg = 0, p_phi1 = 1, p_rb = 0, p_clb = 0, p_la = 0;
   int tg_rise_t = -1, tg_fall_t = 0, tg_w = 0, first_fall_t = -1;
   int phi1_falls = 0, phi1_fall_t = 0, phi1_rise_t = 0, hl_bad = 0;
   int la_bad = 0, la_fall_t = 0, falls_at_end = 0, lines_done = 0;
   int rb_rise_t = 0, rb_in_tg = 0, rb_bad = 0, clb_rise_t = 0, clb_w = 0;
   int clb_bad = 0, align_bad = 0, ovl = 0, lrb_bad = 0, clb_out = 0, compl_bad = 0;
   int exp_rb = 0, exp_clb = 0;
   logic chk_bit = 0, chk_line = 0;

   always @(negedge clk) begin
      t++;
      if (rst_n) begin
         if (phi2 !== ~phi1 || phi1_last !== phi1) compl_bad++;
         if (tg && !p_tg) begin
            tg_rise_t = t; phi1_falls = 0; rb_in_tg = 0; first_fall_t = -1;
         end
         if (!tg && p_tg) begin tg_w = t - tg_rise_t; tg_fall_t = t; end
         if (!phi1 && p_phi1) begin
            if (first_fall_t < 0) first_fall_t = t;
            if (phi1_falls > 0 && t - phi1_rise_t != H) hl_bad++;
            phi1_falls++; phi1_fall_t = t;
         end
         if (phi1 && !p_phi1) begin
            if (t - phi1_fall_t != H) hl_bad++;
            phi1_rise_t = t;
         end
         if (line_active && !p_la && !(tg && !p_tg)) la_bad++;
         if (!line_active && p_la) begin
            if (!(phi1 && !p_phi1)) la_bad++;
            la_fall_t = t; falls_at_end = phi1_falls; lines_done++;
         end
         if (rb && !p_rb) begin rb_rise_t = t; if (tg) rb_in_tg++; end
         if (!rb && p_rb && chk_bit && (t - rb_rise_t) != exp_rb) rb_bad++;
         if (clb && !p_clb) begin
            clb_rise_t = t;
            if (chk_bit && !(p_rb && !rb)) align_bad++;
         end
         if (!clb && p_clb) begin
            clb_w = t - clb_rise_t;
            if (chk_bit && clb_w != exp_clb) clb_bad++;
         end
         if (chk_bit && rb && clb) ovl++;
         if (chk_line) begin
            if (tg && !rb) lrb_bad++;
            if (clb && !tg) clb_out++;
         end
      end
      p_tg = tg; p_phi1 = phi1; p_rb = rb; p_clb = clb; p_la = line_active;
   end

   task automatic set_cfg(int s, int g, int h, int r, int c, int ld, int lg, logic m);
      chk_bit = 0; chk_line = 0;
      cfg_setup = TW'(s); cfg_tg = TW'(g); cfg_hold = TW'(h); cfg_rb = TW'(r);
      cfg_clb = TW'(c); cfg_lead = TW'(ld); cfg_lag = TW'(lg); clamp_line = m;
      repeat (2 * H + 2) @(negedge clk);
      #2;
   endtask

   task automatic pulse_start(output int k);
      @(negedge clk); #2;
      k = t; start_line = 1'b1;
      @(negedge clk); #2;
      start_line = 1'b0;
   endtask

   task automatic wait_done();
      int ld = lines_done;
      while (lines_done == ld) @(negedge clk);
      #2;
   endtask

   task automatic line_checks(int k, int s, int g, int h);
      check("R3 tg rise cycle", tg_rise_t, k + 1 + s);
      check("R4 tg width", tg_w, g);
      check("R5 hold gap in window", int'(first_fall_t >= tg_fall_t + h + H &&
            first_fall_t <= tg_fall_t + h + 3 * H - 1), 1);
      check("R6 shift cycles per line", falls_at_end, L);
   endtask

   int k, lf;
   int gs [3] = '{12, 13, 25};

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check("R1 phi1 in reset", int'(phi1), 1);
      check("R1 phi2 in reset", int'(phi2), 0);
      check("R1 tg in reset", int'(tg), 0);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check("R1 line_active after reset", int'(line_active), 0);
      check("R1 clb after reset", int'(clb), 0);
      check("R1 phi1_last after reset", int'(phi1_last), 1);

      // per-pixel clamp, nominal line
      set_cfg(4, 20, 4, 2, 3, 1, 1, 1'b0);
      exp_rb = 2; exp_clb = 3; chk_bit = 1;
      pulse_start(k);
      wait_done();
      line_checks(k, 4, 20, 4);
      check("R6 half periods", hl_bad, 0);
      check("R7 line_active edges", la_bad, 0);
      check("R8 rb width", rb_bad, 0);
      check("R8 clb width", clb_bad, 0);
      check("R8 clb follows rb", align_bad, 0);
      check("R8 no overlap", ovl, 0);
      check("R8 pulses during tg", int'(rb_in_tg > 0), 1);

      // per-pixel clamp cut at pixel end
      set_cfg(4, 20, 4, 2, 10, 1, 1, 1'b0);
      exp_rb = 2; exp_clb = H - 2; chk_bit = 1;
      pulse_start(k);
      wait_done();
      check("R8 clipped clb width", clb_bad, 0);
      check("R8 clipped clb last", clb_w, H - 2);

      // per-line clamp
      set_cfg(4, 20, 4, 2, 3, 3, 2, 1'b1);
      chk_line = 1;
      pulse_start(k);
      wait_done();
      line_checks(k, 4, 20, 4);
      check("R9 clb rise after lead", clb_rise_t, tg_rise_t + 3);
      check("R9 clb width", clb_w, 20 - 3 - 2);
      check("R9 rb high during tg", lrb_bad, 0);
      check("R9 clb only inside tg", clb_out, 0);

      // strobe held while a line reads out
      set_cfg(5, 14, 3, 2, 3, 1, 1, 1'b0);
      exp_rb = 2; exp_clb = 3; chk_bit = 1;
      pulse_start(k);
      while (tg_rise_t <= k) @(negedge clk);
      while (phi1_falls < 2) @(negedge clk);
      pulse_start(k);
      wait_done();
      lf = la_fall_t;
      check("R10 current line not cut", falls_at_end, L);
      while (tg_rise_t <= lf) @(negedge clk);
      check("R10 next tg after line end", tg_rise_t, lf + 5);
      wait_done();
      check("R10 second line length", falls_at_end, L);

      // zero registers take typical values
      set_cfg(0, 0, 0, 0, 0, 0, 0, 1'b0);
      exp_rb = TYP_RB; exp_clb = TYP_CLB; chk_bit = 1;
      pulse_start(k);
      wait_done();
      line_checks(k, TYP_SETUP, TYP_TG, TYP_HOLD);
      check("R11 default rb width", rb_bad, 0);
      check("R11 default clb width", clb_bad, 0);

      // sweep of setup and gate width
      foreach (gs[i]) begin
         for (int s = 1; s <= 3; s++) begin
            set_cfg(s, gs[i], 2, 1, 2, 1, 1, 1'b0);
            exp_rb = 1; exp_clb = 2; chk_bit = 1;
            pulse_start(k);
            wait_done();
            line_checks(k, s, gs[i], 2);
         end
      end
      check("R6 half periods after sweep", hl_bad, 0);
      check("R7 line_active after sweep", la_bad, 0);
      check("R2 phase relation", compl_bad, 0);
      check("R8 overlap after sweep", ovl, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule